// File: doc/BRIEF.md
# Reset Cause Recording Register

This block keeps a software-visible record of why the processor was last reset. It watches the processor reset indication, a reset-category hint from the power manager and the non-debug-module reset request. While the processor is held in reset it sets sticky cause bits, but only for causes that the hint authorizes. Software clears a bit by writing 1 to it. The block's own reset is the power-on reset, so the power-on bit comes out of reset already set. Recording stays muted after power-on until the processor has left reset once.

The block also holds a small capture buffer for alert crash-dump words. The words arrive on a valid/ready stream while the capture enable is set. The enable drops by itself whenever the processor is reset, and that freezes the buffer so software can read it after the restart. Software reads the buffer one 32-bit word at a time. It picks the word with an index field, and a read-only count tells it how many words are held.

The register port is a plain write strobe with a combinational read. Every register decodes address bits [3:2]. Cause register at 0x0, control at 0x4, word count at 0x8, selected dump word at 0xC.

Top module: `rst_reason_rec`

## Requirements
- R1: Out of reset (rst_ni low) the cause register reads 0x1 (power-on bit set), the control register reads 0x0, the count reads 0 and the dump word reads 0.
- R2: The cause register (0x0) has power-on at bit 0, low-power exit at bit 1, non-debug-module reset at bit 2 and peripheral request at bit 3. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R3: After power-on, nothing is recorded until cpu_rst_ni has been sampled high at least once.
- R4: While armed and cpu_rst_ni is low, a hint of 2'b01 (low-power reset) sets bit 1 and a hint of 2'b10 (peripheral reset) sets bit 3 on each rising clock edge.
- R5: The non-debug-module request sets bit 2 only when the hint is 2'b00 (no power-manager activity). It is ignored under any other hint.
- R6: Recorded causes accumulate by OR and never clear other bits.
- R7: If software writes 1 to a cause bit in the same cycle that hardware records that cause, the bit ends up set.
- R8: The control register (0x4) holds the capture enable at bit 0 and the word index at bits 7:4. The enable is forced to 0 on any clock edge where cpu_rst_ni is low, and the index is kept.
- R9: dump_ready_o is high exactly when the enable is set and fewer than DUMP_DEPTH words are held. A beat with valid and ready both high is stored at the next free position. The count appears at 0x8 bits 3:0. A data word held while ready is low is not taken, and the source must keep it until accepted.
- R10: Address 0xC returns the stored word selected by the index when the index is below the count, and 0 otherwise.
- R11: Writing the enable from 0 to 1 restarts capture with a count of 0. Writing 1 while it is already set keeps the held words.
- R12: No cause is recorded while cpu_rst_ni is high, whatever the hint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| cpu_rst_ni | input | 1 | Processor reset indication, low while the processor is in reset |
| pm_hint_i | input | 2 | Power manager category: 00 none, 01 low-power, 10 peripheral |
| ndm_req_i | input | 1 | Non-debug-module reset request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Byte address, bits [3:2] decoded |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| dump_valid_i | input | 1 | Dump word valid |
| dump_ready_o | output | 1 | Dump word accepted when high together with valid |
| dump_data_i | input | 32 | Dump word |

## Verification
The cause logic is driven with each hint value while the processor is in reset, both before and after the first release. This tells muted recording apart from authorized recording. The non-debug request is applied under a peripheral hint and under no hint, which separates direct recording from recording that the hint suppresses. A clear and a hardware set are made to land in the same cycle, and causes are stacked without clearing in between, so priority and accumulation are both shown. The dump stream is pushed past its depth, frozen by a processor reset, restarted, and read at indices below, at and above the count.

// File: rtl/rrr_pkg.sv
package rrr_pkg;
  localparam int REG_W   = 32;
  localparam int CAUSE_W = 4;
  localparam int IDX_W   = 4;

  localparam int CB_POR = 0;
  localparam int CB_LPX = 1;
  localparam int CB_NDM = 2;
  localparam int CB_HWR = 3;

  typedef enum logic [1:0] {
    HINT_NONE   = 2'd0,
    HINT_LOWPWR = 2'd1,
    HINT_PERIPH = 2'd2
  } hint_e;

  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_CNT   = 2'd2,
    SEL_WORD  = 2'd3
  } sel_e;
endpackage

// File: rtl/rrr_cause.sv
module rrr_cause
  import rrr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_rst_ni,
  input  logic [1:0]         hint_i,
  input  logic               ndm_req_i,
  input  logic               clr_we_i,
  input  logic [CAUSE_W-1:0] clr_mask_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               armed_q;
  logic [CAUSE_W-1:0] cause_q, set_vec, clr_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (cpu_rst_ni) armed_q <= 1'b1;
  end

  always_comb begin
    set_vec = '0;
    if (armed_q && !cpu_rst_ni) begin
      case (hint_i)
        HINT_NONE:   set_vec[CB_NDM] = ndm_req_i;
        HINT_LOWPWR: set_vec[CB_LPX] = 1'b1;
        HINT_PERIPH: set_vec[CB_HWR] = 1'b1;
        default:     set_vec = '0;
      endcase
    end
  end

  assign clr_vec = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= CAUSE_W'(1) << CB_POR;
    else cause_q <= (cause_q & ~clr_vec) | set_vec;
  end

  assign cause_o = cause_q;

  AST_MUTED_UNTIL_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !clr_we_i) |=> $stable(cause_q)) else $error("muted"); // R3
  AST_LOWPWR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !cpu_rst_ni && hint_i == HINT_LOWPWR) |=> cause_q[CB_LPX]) else $error("lpx"); // R7
  AST_NDM_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hint_i != HINT_NONE && !cause_q[CB_NDM]) |=> !cause_q[CB_NDM]) else $error("ndm"); // R5
  AST_IDLE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_ni |=> ((cause_q & ~$past(cause_q)) == '0)) else $error("idle"); // R12
endmodule

// File: rtl/rrr_dump.sv
module rrr_dump
  import rrr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_rst_ni,
  input  logic             ctrl_we_i,
  input  logic [REG_W-1:0] ctrl_wdata_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [REG_W-1:0] in_data_i,
  output logic             en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic [REG_W-1:0] word_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             en_q, restart, accept;
  logic [IDX_W-1:0] idx_q, cnt_ext;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] mem_q [DEPTH];

  assign restart    = ctrl_we_i && ctrl_wdata_i[0] && !en_q && cpu_rst_ni;
  assign in_ready_o = en_q && (cnt_q < CNT_W'(DEPTH));
  assign accept     = in_valid_i && in_ready_o;
  assign cnt_ext    = IDX_W'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      if (ctrl_we_i) idx_q <= ctrl_wdata_i[7:4];
      if (!cpu_rst_ni) en_q <= 1'b0;
      else if (ctrl_we_i) en_q <= ctrl_wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (accept) cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (accept && cnt_q == CNT_W'(i)) mem_q[i] <= in_data_i;
    end
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (idx_q == IDX_W'(i) && IDX_W'(i) < cnt_ext) word_o = mem_q[i];
  end

  assign en_o  = en_q;
  assign idx_o = idx_q;
  assign cnt_o = cnt_ext;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)) else $error("overflow"); // R9
  AST_EN_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rst_ni |=> !en_q) else $error("en"); // R8
  AST_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q >= cnt_ext) |-> (word_o == '0)) else $error("zero"); // R10
  AST_NO_TAKE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !restart) |=> $stable(cnt_q)) else $error("take"); // R9
endmodule

// File: rtl/rst_reason_rec.sv
module rst_reason_rec
  import rrr_pkg::*;
#(
  parameter int DUMP_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cpu_rst_ni,
  input  logic [1:0]  pm_hint_i,
  input  logic        ndm_req_i,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        dump_valid_i,
  output logic        dump_ready_o,
  input  logic [31:0] dump_data_i
);
  logic [CAUSE_W-1:0] cause;
  logic               en;
  logic [IDX_W-1:0]   idx, cnt;
  logic [REG_W-1:0]   word;
  logic [1:0]         sel;

  assign sel = reg_addr_i[3:2];

  rrr_cause u_cause (
    .clk_i, .rst_ni, .cpu_rst_ni,
    .hint_i     (pm_hint_i),
    .ndm_req_i,
    .clr_we_i   (reg_we_i && sel == SEL_CAUSE),
    .clr_mask_i (reg_wdata_i[CAUSE_W-1:0]),
    .cause_o    (cause)
  );

  rrr_dump #(.DEPTH(DUMP_DEPTH)) u_dump (
    .clk_i, .rst_ni, .cpu_rst_ni,
    .ctrl_we_i    (reg_we_i && sel == SEL_CTRL),
    .ctrl_wdata_i (reg_wdata_i),
    .in_valid_i   (dump_valid_i),
    .in_ready_o   (dump_ready_o),
    .in_data_i    (dump_data_i),
    .en_o         (en),
    .idx_o        (idx),
    .cnt_o        (cnt),
    .word_o       (word)
  );

  always_comb begin
    case (sel)
      SEL_CAUSE: reg_rdata_o = REG_W'(cause);
      SEL_CTRL:  reg_rdata_o = REG_W'({idx, 3'b000, en});
      SEL_CNT:   reg_rdata_o = REG_W'(cnt);
      default:   reg_rdata_o = word;
    endcase
  end
endmodule

// File: tb/test_rst_reason_rec.sv
`timescale 1ns/1ps
module test_rst_reason_rec;
  logic clk = 0, rst_ni = 0, cpu_rst_ni = 0, ndm_req = 0, we = 0;
  logic dvalid = 0, dready;
  logic [1:0] hint = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata, ddata = 0;
  int errors = 0, total = 0, mcnt = 0;
  logic [31:0] mwords [4];

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sb[$];
  event ev_rd;

  always #2.5 clk = ~clk;

  rst_reason_rec i_rst_reason_rec (
    .clk_i(clk), .rst_ni, .cpu_rst_ni, .pm_hint_i(hint), .ndm_req_i(ndm_req),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .dump_valid_i(dvalid), .dump_ready_o(dready), .dump_data_i(ddata));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read results appear
  initial forever begin
    exp_t e;
    @(ev_rd);
    e = sb.pop_front();
    chk(e.tag, rdata, e.v);
  end

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    exp_t e;
    @(negedge clk);
    addr = a;
    e.v = exp; e.tag = tag;
    sb.push_back(e);
    #1 -> ev_rd;
    #0.1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic cpu_pulse(logic [1:0] h, logic n, int cyc);
    @(negedge clk);
    cpu_rst_ni = 0; hint = h; ndm_req = n;
    if (h == 0 && n == 0) mcnt = mcnt; // causes nothing
    repeat (cyc) @(negedge clk);
    cpu_rst_ni = 1; hint = 0; ndm_req = 0;
  endtask

  task automatic push(logic [31:0] d);
    @(negedge clk);
    dvalid = 1; ddata = d;
    if (dready) begin
      mwords[mcnt] = d;
      mcnt++;
    end
    @(negedge clk);
    dvalid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    rd(4'h0, 32'h1, "R1 cause");
    rd(4'h4, 32'h0, "R1 ctrl");
    rd(4'h8, 32'h0, "R1 count");
    rd(4'hC, 32'h0, "R1 word");
    // muted before first release
    @(negedge clk); hint = 2'b01; ndm_req = 1;
    repeat (3) @(negedge clk);
    hint = 2'b10;
    repeat (2) @(negedge clk);
    rd(4'h0, 32'h1, "R3 muted");
    hint = 0; ndm_req = 0;
    @(negedge clk); cpu_rst_ni = 1;
    hint = 2'b10; ndm_req = 1;
    repeat (3) @(negedge clk);
    hint = 0; ndm_req = 0;
    rd(4'h0, 32'h1, "R12 running");
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h1, "R2 write0");
    wr(4'h0, 32'h1);
    rd(4'h0, 32'h0, "R2 w1c");
    cpu_pulse(2'b01, 0, 1);
    rd(4'h0, 32'h2, "R4 lowpwr");
    cpu_pulse(2'b10, 0, 1);
    rd(4'h0, 32'hA, "R6 accumulate");
    wr(4'h0, 32'hF);
    rd(4'h0, 32'h0, "R2 clear all");
    cpu_pulse(2'b10, 1, 2);
    rd(4'h0, 32'h8, "R5 ndm ignored");
    wr(4'h0, 32'hF);
    cpu_pulse(2'b00, 1, 1);
    rd(4'h0, 32'h4, "R5 ndm recorded");
    wr(4'h0, 32'hF);
    // hardware set wins over clear
    @(negedge clk);
    cpu_rst_ni = 0; hint = 2'b01; we = 1; addr = 4'h0; wdata = 32'h2;
    @(negedge clk);
    we = 0; cpu_rst_ni = 1; hint = 0;
    rd(4'h0, 32'h2, "R7 set wins");
    wr(4'h0, 32'hF);
    // dump capture
    wr(4'h4, 32'h1);
    mcnt = 0;
    @(negedge clk); chk("R9 ready", {31'b0, dready}, 32'h1);
    for (int i = 0; i < 5; i++) push(32'hA000_0000 + i);
    @(negedge clk); chk("R9 ready full", {31'b0, dready}, 32'h0);
    rd(4'h8, 32'(mcnt), "R9 count");
    wr(4'h4, 32'h21);
    rd(4'h8, 32'h4, "R11 no restart");
    rd(4'hC, mwords[2], "R10 word2");
    rd(4'h4, 32'h21, "R8 ctrl");
    cpu_pulse(2'b00, 0, 1);
    rd(4'h4, 32'h20, "R8 en cleared");
    rd(4'h8, 32'h4, "R8 frozen");
    rd(4'h0, 32'h0, "R12 no cause");
    wr(4'h4, 32'h01);
    rd(4'h8, 32'h0, "R11 restart");
    rd(4'hC, 32'h0, "R10 empty");
    mcnt = 0;
    push(32'hB000_0000);
    push(32'hB000_0001);
    wr(4'h4, 32'h30);
    @(negedge clk); chk("R9 ready off", {31'b0, dready}, 32'h0);
    push(32'hC000_0000);
    rd(4'h8, 32'h2, "R9 held");
    rd(4'hC, 32'h0, "R10 beyond");
    wr(4'h4, 32'h10);
    rd(4'hC, 32'hB000_0001, "R10 word1");
    wr(4'h4, 32'hF0);
    rd(4'hC, 32'h0, "R10 idx15");
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule